// File: doc/BRIEF.md
# Dual-Channel Down-Counting Event Timer

This block is a register-mapped timer with two channels that each count down from a 64-bit interval. Each channel has its own control word, a two-word interval and a two-word live count that software can read. The channels share one interrupt-enable word and one pending-flag word. A single-cycle `tick_en` input stands for one cycle of the timer clock. Each channel divides that tick by a power of two that software selects. When a channel reaches the end of its count, it either reloads the interval and carries on (periodic) or parks at zero and turns itself off (one-shot).

Each channel is driven by a three-state machine:

- **IDLE**: the count is held.
- **RUN**: the count decrements on each prescaled tick.
- **DRAIN**: enable has been cleared, but the channel keeps counting for a fixed number of raw timer ticks before it really stops.

The transitions are:

- **start**: IDLE to RUN, on a control write with enable set.
- **halt-request**: RUN to DRAIN, on a control write with enable clear.
- **resume**: DRAIN to RUN, on a control write with enable set.
- **drained**: DRAIN to IDLE, when the stop lag has elapsed.
- **expire-oneshot**: RUN or DRAIN to IDLE, when the count ends with one-shot selected.

Software builds an up-counting timestamp by inverting the low count word. A read of the low count word latches the high word, so that a 64-bit value taken in two reads is consistent.

Top module: `downcount_timer`

## Requirements
- R1: After reset every register reads 0: irq-enable at 0x00, pending at 0x04, and every channel word. `irq` is low.
- R2: Channel n uses the following word offsets, with the stride 0x20 taken from `0x20*n`:
  - control at 0x10
  - interval low at 0x14
  - interval high at 0x18
  - count low at 0x1C
  - count high at 0x20
- R3: The control word has enable at bit 0, reload strobe at bit 1, prescale select at bits 6:4 and one-shot at bit 7. A control write with bit 1 set copies the 64-bit interval into the count in that cycle. Bit 1 always reads back 0.
- R4: In one-shot mode, a prescaled tick that finds the count at 1 or 0 sets the count to 0, clears the enable bit and stops the channel. Further ticks leave the count at 0.
- R5: In periodic mode, a prescaled tick that finds the count at 1 or 0 loads the interval and counting continues. Any other prescaled tick decrements the count by one, so an interval of N gives a period of N ticks.
- R6: After a control write clears enable, the channel keeps counting for exactly 2 further raw ticks and then holds its count.
- R7: With select value s, the count decrements once every 2^s raw ticks. The phase is counted from the start transition.
- R8: An expiry sets bit n of the pending word whether or not interrupt n is enabled. If an expiry and a clear land in the same cycle, the expiry wins.
- R9: Writing 1 to pending bit n clears it. Writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some channel has both its pending bit and its enable bit (bit n of 0x00) set.
- R11: A read of count low latches that channel's count high. A later read of count high returns the latched value, even if the count has moved in between.
- R12: The channels are independent: activity on one never changes the other's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle timer-clock tick |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address of the word |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from address |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults:

- two channels
- 32-bit bus words and 64-bit counts
- a 3-bit prescale select
- a two-tick stop lag

With 64-bit counts, a borrow out of the low word can be provoked from a small interval whose high word is 1, which exercises the high-word latch. The bench controls `tick_en` directly, so it sets the exact number of raw ticks seen by the stop lag, the divide-by-four prescaler and the one-shot expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_e;

    localparam int unsigned OFS_IRQ_EN = 32'h00;
    localparam int unsigned OFS_IRQ_ST = 32'h04;
    localparam int unsigned CH_BASE    = 32'h10;
    localparam int unsigned CH_STRIDE  = 32'h20;
    localparam int unsigned OFS_CTL    = 32'h00;
    localparam int unsigned OFS_IVL_LO = 32'h04;
    localparam int unsigned OFS_IVL_HI = 32'h08;
    localparam int unsigned OFS_CNT_LO = 32'h0C;
    localparam int unsigned OFS_CNT_HI = 32'h10;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_RLD_BIT = 1;
    localparam int CTL_PS_LSB  = 4;
    localparam int CTL_OS_BIT  = 7;

    typedef struct packed {
        logic       oneshot;
        logic [2:0] psel;
        logic       enable;
    } ctl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            active,
    input  logic            tick_en,
    input  logic [PS_W-1:0] sel,
    output logic            pulse
);
    localparam int DIV_W = (2 ** PS_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask;

    always_comb begin
        for (int b = 0; b < DIV_W; b++) begin
            mask[b] = (b < int'(sel));
        end
    end

    assign pulse = tick_en && active && ((div_cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            div_cnt <= '0;
        end else if (tick_en && active) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 64,
    parameter int PS_W  = 3,
    parameter int LAG   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ctl_we,
    input  logic             ivl_lo_we,
    input  logic             ivl_hi_we,
    input  logic [DW-1:0]    wdata,
    output ctl_t             ctl_q,
    output logic [CNT_W-1:0] ivl_q,
    output logic [CNT_W-1:0] count_q,
    output logic             expire,
    output logic             running
);
    localparam int HI_W  = CNT_W - DW;
    localparam int LAG_W = $clog2(LAG + 1);

    ch_state_e        state, nxt;
    logic [LAG_W-1:0] lag_q;
    logic             ps_tick;
    logic             at_end;
    logic             wr_on;
    logic             wr_off;
    logic             os_stop;

    assign wr_on   = ctl_we &&  wdata[CTL_EN_BIT];
    assign wr_off  = ctl_we && !wdata[CTL_EN_BIT];
    assign at_end  = (count_q <= CNT_W'(1));
    assign expire  = ps_tick && at_end;
    assign os_stop = expire && ctl_q.oneshot;
    assign running = (state != CH_IDLE);

    tmr_prescale #(.PS_W(PS_W)) u_ps (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  ((state == CH_IDLE) && (nxt == CH_RUN)),
        .active (state != CH_IDLE),
        .tick_en(tick_en),
        .sel    (ctl_q.psel),
        .pulse  (ps_tick)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            CH_IDLE: begin
                if (wr_on) nxt = CH_RUN;
            end
            CH_RUN: begin
                if (os_stop)     nxt = CH_IDLE;
                else if (wr_off) nxt = CH_DRAIN;
            end
            CH_DRAIN: begin
                if (os_stop)                                nxt = CH_IDLE;
                else if (wr_on)                             nxt = CH_RUN;
                else if (tick_en && lag_q == LAG_W'(1))     nxt = CH_IDLE;
            end
            default: nxt = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt;
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            ivl_q   <= '0;
            count_q <= '0;
            lag_q   <= '0;
        end else begin
            if (ivl_lo_we) ivl_q[DW-1:0]    <= wdata;
            if (ivl_hi_we) ivl_q[CNT_W-1:DW] <= wdata[HI_W-1:0];

            if (ctl_we) begin
                ctl_q.enable  <= wdata[CTL_EN_BIT];
                ctl_q.psel    <= wdata[CTL_PS_LSB +: 3];
                ctl_q.oneshot <= wdata[CTL_OS_BIT];
            end
            if (os_stop) ctl_q.enable <= 1'b0;

            if (ctl_we && wdata[CTL_RLD_BIT]) count_q <= ivl_q;
            else if (expire)                  count_q <= ctl_q.oneshot ? '0 : ivl_q;
            else if (ps_tick)                 count_q <= count_q - 1'b1;

            if (state == CH_RUN && nxt == CH_DRAIN)    lag_q <= LAG_W'(LAG);
            else if (state == CH_DRAIN && tick_en)     lag_q <= lag_q - 1'b1;
        end
    end
endmodule

// File: rtl/downcount_timer.sv
module downcount_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int AW       = 8,
    parameter int DW       = 32,
    parameter int CNT_W    = 64,
    parameter int PS_W     = 3,
    parameter int STOP_LAG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam int HI_W = CNT_W - DW;

    logic             wr_cyc, rd_cyc;
    logic [NUM_CH-1:0] irq_en, irq_status;
    logic [NUM_CH-1:0] ch_expire, ch_oneshot, ch_running;
    logic [NUM_CH-1:0] ch_hit;
    logic [DW-1:0]     ch_word [NUM_CH];
    logic              st_wr;

    assign wr_cyc = bus_valid &&  bus_write;
    assign rd_cyc = bus_valid && !bus_write;
    assign st_wr  = wr_cyc && (bus_addr == AW'(OFS_IRQ_ST));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int unsigned BASE = CH_BASE + CH_STRIDE * i;

        ctl_t             ctl;
        logic [CNT_W-1:0] ivl, cnt;
        logic [HI_W-1:0]  shadow_hi;
        logic             a_ctl, a_il, a_ih, a_cl, a_ch;

        assign a_ctl = (bus_addr == AW'(BASE + OFS_CTL));
        assign a_il  = (bus_addr == AW'(BASE + OFS_IVL_LO));
        assign a_ih  = (bus_addr == AW'(BASE + OFS_IVL_HI));
        assign a_cl  = (bus_addr == AW'(BASE + OFS_CNT_LO));
        assign a_ch  = (bus_addr == AW'(BASE + OFS_CNT_HI));

        tmr_channel #(
            .DW(DW), .CNT_W(CNT_W), .PS_W(PS_W), .LAG(STOP_LAG)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_en),
            .ctl_we   (wr_cyc && a_ctl),
            .ivl_lo_we(wr_cyc && a_il),
            .ivl_hi_we(wr_cyc && a_ih),
            .wdata    (bus_wdata),
            .ctl_q    (ctl),
            .ivl_q    (ivl),
            .count_q  (cnt),
            .expire   (ch_expire[i]),
            .running  (ch_running[i])
        );

        assign ch_oneshot[i] = ctl.oneshot;

        always_ff @(posedge clk) begin
            if (!rst_n)               shadow_hi <= '0;
            else if (rd_cyc && a_cl)  shadow_hi <= cnt[CNT_W-1:DW];
        end

        assign ch_hit[i] = a_ctl | a_il | a_ih | a_cl | a_ch;

        always_comb begin
            ch_word[i] = '0;
            if (a_ctl) begin
                ch_word[i][CTL_EN_BIT]         = ctl.enable;
                ch_word[i][CTL_PS_LSB +: 3]    = ctl.psel;
                ch_word[i][CTL_OS_BIT]         = ctl.oneshot;
            end
            else if (a_il) ch_word[i]         = ivl[DW-1:0];
            else if (a_ih) ch_word[i][HI_W-1:0] = ivl[CNT_W-1:DW];
            else if (a_cl) ch_word[i]         = cnt[DW-1:0];
            else if (a_ch) ch_word[i][HI_W-1:0] = shadow_hi;
        end
    end

    // shared enable and pending words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en     <= '0;
            irq_status <= '0;
        end else begin
            if (wr_cyc && bus_addr == AW'(OFS_IRQ_EN)) irq_en <= bus_wdata[NUM_CH-1:0];
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_expire[i])                  irq_status[i] <= 1'b1;
                else if (st_wr && bus_wdata[i])    irq_status[i] <= 1'b0;
            end
        end
    end

    assign irq = |(irq_status & irq_en);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_IRQ_EN))      bus_rdata[NUM_CH-1:0] = irq_en;
        else if (bus_addr == AW'(OFS_IRQ_ST)) bus_rdata[NUM_CH-1:0] = irq_status;
        else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_hit[i]) bus_rdata = ch_word[i];
            end
        end
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int NUM_CH = 2,
    parameter int AW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [AW-1:0]     bus_addr,
    input logic [NUM_CH-1:0] wdata_lo,
    input logic              irq,
    input logic [NUM_CH-1:0] expire,
    input logic [NUM_CH-1:0] oneshot,
    input logic [NUM_CH-1:0] running,
    input logic [NUM_CH-1:0] status
);
    logic clr_wr;
    assign clr_wr = bus_valid && bus_write && (bus_addr == AW'(4));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        // R4: one-shot expiry parks the channel
        a_r4_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] && oneshot[i] |=> !running[i]);
        // R8: expiry always raises the pending flag
        a_r8_status_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] |=> status[i]);
        // R9: write-one clears when no expiry competes
        a_r9_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
            clr_wr && wdata_lo[i] && !expire[i] |=> !status[i]);
    end

    // R10: no request without some pending flag
    a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

bind downcount_timer tmr_checker #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .wdata_lo (bus_wdata[NUM_CH-1:0]),
    .irq      (irq),
    .expire   (ch_expire),
    .oneshot  (ch_oneshot),
    .running  (ch_running),
    .status   (irq_status)
);

// File: tb/test_downcount_timer.sv
module test_downcount_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    downcount_timer i_downcount_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (rst_n && bus_valid && !bus_write) begin
            if (exp_q.size() == 0) check(bus_rdata, 32'hx, "scoreboard empty");
            else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #2;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk); #2;
        bus_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #2;
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #2 tick_en = 1'b0;
    endtask

    task automatic irq_is(input logic e, input string tag);
        @(negedge clk);
        check({31'b0, irq}, {31'b0, e}, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, 32'h0, "R1 irq enable");
        rd(8'h04, 32'h0, "R1 pending");
        rd(8'h10, 32'h0, "R1 ctl0");
        rd(8'h1C, 32'h0, "R1 count0 lo");
        irq_is(1'b0, "R1 irq low");
        // R2 / R3 interval and reload
        wr(8'h14, 32'd10);
        wr(8'h18, 32'd0);
        rd(8'h14, 32'd10, "R2 interval lo");
        wr(8'h10, 32'h3);
        rd(8'h10, 32'h1, "R3 reload reads 0");
        rd(8'h1C, 32'd10, "R3 count loaded");
        // R5 periodic
        ticks(4);
        rd(8'h1C, 32'd6, "R5 decrement");
        ticks(5);
        rd(8'h1C, 32'd1, "R5 before expiry");
        rd(8'h04, 32'h0, "R8 not yet pending");
        ticks(1);
        rd(8'h1C, 32'd10, "R5 reload on expiry");
        rd(8'h04, 32'h1, "R8 pending while disabled");
        irq_is(1'b0, "R10 masked");
        rd(8'h3C, 32'h0, "R12 ch1 untouched");
        // R10 / R9
        wr(8'h00, 32'h1);
        irq_is(1'b1, "R10 raised");
        wr(8'h04, 32'h0);
        rd(8'h04, 32'h1, "R9 zero write ignored");
        wr(8'h04, 32'h1);
        rd(8'h04, 32'h0, "R9 one clears");
        irq_is(1'b0, "R10 dropped");
        // R6 stop lag
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h0, "R6 enable reads off");
        ticks(5);
        rd(8'h1C, 32'd8, "R6 two lag ticks");
        // R4 one-shot
        wr(8'h14, 32'd3);
        wr(8'h10, 32'h83);
        ticks(2);
        rd(8'h1C, 32'd1, "R4 counting");
        ticks(1);
        rd(8'h1C, 32'd0, "R4 parked at zero");
        rd(8'h10, 32'h80, "R4 enable cleared");
        rd(8'h04, 32'h1, "R8 one-shot pending");
        irq_is(1'b1, "R10 one-shot irq");
        ticks(3);
        rd(8'h1C, 32'd0, "R4 stays stopped");
        wr(8'h04, 32'h1);
        irq_is(1'b0, "R9 cleared irq");
        // R7 prescaler divide by 4
        wr(8'h34, 32'd100);
        wr(8'h38, 32'd0);
        wr(8'h30, 32'h23);
        ticks(7);
        rd(8'h3C, 32'd99, "R7 first divided tick");
        ticks(1);
        rd(8'h3C, 32'd98, "R7 second divided tick");
        ticks(3);
        rd(8'h3C, 32'd98, "R7 between divided ticks");
        ticks(1);
        rd(8'h3C, 32'd97, "R7 third divided tick");
        rd(8'h1C, 32'd0, "R12 ch0 untouched");
        // R11 high-word latch and 64-bit borrow
        wr(8'h38, 32'd1);
        wr(8'h34, 32'd5);
        wr(8'h30, 32'h3);
        rd(8'h3C, 32'd5, "R11 low word");
        ticks(6);
        rd(8'h40, 32'd1, "R11 latched high");
        rd(8'h3C, 32'hFFFF_FFFF, "R2 borrow into low");
        rd(8'h40, 32'd0, "R11 new high");
        rd(8'h04, 32'h0, "R8 no ch1 expiry");
        wr(8'h00, 32'h2);
        irq_is(1'b0, "R10 ch1 nothing pending");
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule